// File: doc/BRIEF.md
# Debug control-register read sequencer

This block is the command engine behind a debug port. It serves a single command: reading one processor control register. The host exchanges 16-bit words with it in full-duplex packets. On every exchange the host hands in one word and at the same moment takes out a 17-bit response: a status flag and a 16-bit data word. The engine recognises the command word and collects two extension words that together form a 32-bit address. It then runs one 32-bit read on a simple control-register port with request, acknowledge, error and data lines.

While the engine gathers operands, and while the port access is outstanding, every response is "not ready". Once the access completes, the next two exchanges return the upper and then the lower half of the result. The word the host sends alongside the lower half is already treated as the next command. A failed access produces a distinct bus-error response in place of the two result words.

The address is forwarded to the port without change. Deciding which selectors exist, and rejecting nonzero reserved address bits, is the job of the register port, which reports such cases through its error line.

Top module: `dcr_read_seq`

## Requirements
- R1: After reset the pending response is "not ready" (status 1, data 0x0000) and `creg_req` is low.
- R2: While waiting for a command, any word other than 0x2980 is ignored: no request is issued, the response stays "not ready", and the following words are not taken as operands.
- R3: The exchanges that carry the command word and the two extension words each return "not ready" (status 1, data 0x0000).
- R4: The request address is {first extension word, second extension word}, with the first word in bits 31:16. `creg_req` stays high with a stable address until `creg_ack` or `creg_err` is seen.
- R5: An exchange made while the access is pending returns "not ready" and does not disturb the result that follows.
- R6: After a successful access, the next exchange returns result bits 31:16 with status 0, and the exchange after that returns bits 15:0 with status 0.
- R7: The word received with the lower result half is decoded as the next command. If it is 0x2980 a new read starts; any other word returns the engine to waiting, with "not ready" pending.
- R8: If the access ends with `creg_err` (error wins over a simultaneous acknowledge), the next exchange returns a bus-error response (status 1, data 0x0001) instead of the result. The word received with it is decoded as a command, and "not ready" follows.
- R9: Exactly one request is made per command. `creg_req` drops in the cycle after acknowledge or error and is not raised again without a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_xfer | input | 1 | One packet exchange happens in this cycle |
| host_wdata | input | 16 | Word sent by the host in the exchange |
| host_rdata | output | 16 | Data word of the response returned in the exchange |
| host_rstat | output | 1 | Status flag of the response (0 = valid result word) |
| creg_req | output | 1 | Control-register read request, held until acknowledge or error |
| creg_addr | output | 32 | Address of the requested register |
| creg_ack | input | 1 | Read completed, data valid |
| creg_err | input | 1 | Read failed |
| creg_rdata | input | 32 | Read data, sampled with acknowledge |

## Verification
The hardest case to reach is a host exchange that lands while the register read is still outstanding, followed by a result that must come through intact. The bench gets there by giving its register-port model a long acknowledge latency and exchanging packets immediately after the last extension word, then waiting for the request to drop. The other hard cases are the overlap of the lower result half with a new command word, and the same overlap on a bus-error response. The bench drives both by placing 0x2980 in exactly those exchanges and then completing a second read.

// File: rtl/dcrs_pkg.sv
package dcrs_pkg;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_EXT_HI,
    ST_EXT_LO,
    ST_WAIT,
    ST_RES_HI,
    ST_RES_LO,
    ST_BERR
  } seq_state_e;

  typedef enum logic [2:0] {
    RSP_KEEP,
    RSP_NREADY,
    RSP_HI,
    RSP_LO,
    RSP_BERR
  } rsp_load_e;

endpackage

// File: rtl/dcrs_rst_sync.sv
module dcrs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/dcrs_seq_fsm.sv
module dcrs_seq_fsm
  import dcrs_pkg::*;
#(
  parameter int              WORD_W   = 16,
  parameter logic [WORD_W-1:0] CMD_CODE = 16'h2980
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer,
  input  logic [WORD_W-1:0] wdata,
  input  logic              acc_done,
  input  logic              acc_fail,
  output logic              cap_hi,
  output logic              cap_lo,
  output logic              launch,
  output rsp_load_e         rsp_load
);

  seq_state_e state_q, state_d;
  logic       is_cmd;

  assign is_cmd = (wdata == CMD_CODE);

  // next-state and control decode
  always_comb begin
    state_d  = state_q;
    cap_hi   = 1'b0;
    cap_lo   = 1'b0;
    launch   = 1'b0;
    rsp_load = RSP_KEEP;
    case (state_q)
      ST_CMD: begin
        if (xfer) begin
          rsp_load = RSP_NREADY;
          if (is_cmd) state_d = ST_EXT_HI;
        end
      end
      ST_EXT_HI: begin
        if (xfer) begin
          cap_hi   = 1'b1;
          rsp_load = RSP_NREADY;
          state_d  = ST_EXT_LO;
        end
      end
      ST_EXT_LO: begin
        if (xfer) begin
          cap_lo   = 1'b1;
          launch   = 1'b1;
          rsp_load = RSP_NREADY;
          state_d  = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (acc_fail) begin
          rsp_load = RSP_BERR;
          state_d  = ST_BERR;
        end else if (acc_done) begin
          rsp_load = RSP_HI;
          state_d  = ST_RES_HI;
        end
      end
      ST_RES_HI: begin
        if (xfer) begin
          rsp_load = RSP_LO;
          state_d  = ST_RES_LO;
        end
      end
      ST_RES_LO, ST_BERR: begin
        if (xfer) begin
          rsp_load = RSP_NREADY;
          state_d  = is_cmd ? ST_EXT_HI : ST_CMD;
        end
      end
      default: state_d = ST_CMD;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_CMD;
    else        state_q <= state_d;
  end

  AST_CMD_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CMD && xfer && wdata != CMD_CODE) |=> (state_q == ST_CMD)); // R2

  AST_WAIT_NO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> (!cap_hi && !cap_lo && !launch)); // R5

endmodule

// File: rtl/dcrs_addr_cap.sv
module dcrs_addr_cap #(
  parameter int WORD_W = 16,
  localparam int ADDR_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_hi,
  input  logic              cap_lo,
  input  logic [WORD_W-1:0] wdata,
  output logic [ADDR_W-1:0] addr
);

  logic [WORD_W-1:0] hi_q, lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_q <= '0;
    else if (cap_hi) hi_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lo_q <= '0;
    else if (cap_lo) lo_q <= wdata;
  end

  assign addr = {hi_q, lo_q};

  AST_CAP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_hi && cap_lo)); // R4

endmodule

// File: rtl/dcrs_bus_acc.sv
module dcrs_bus_acc #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              creg_ack,
  input  logic              creg_err,
  input  logic [WORD_W-1:0] rdata_lo,
  output logic              creg_req,
  output logic              acc_done,
  output logic              acc_fail,
  output logic [WORD_W-1:0] lo_word
);

  logic              req_q, req_d;
  logic [WORD_W-1:0] lo_q;

  // error takes priority over a simultaneous acknowledge
  assign acc_fail = req_q & creg_err;
  assign acc_done = req_q & creg_ack & ~creg_err;

  always_comb begin
    req_d = req_q;
    if (launch)                   req_d = 1'b1;
    else if (acc_done || acc_fail) req_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lo_q <= '0;
    else if (acc_done) lo_q <= rdata_lo;
  end

  assign creg_req = req_q;
  assign lo_word  = lo_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !creg_ack && !creg_err) |=> req_q); // R4

  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && (creg_ack || creg_err)) |=> !req_q); // R9

  AST_NO_RELAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !req_q); // R9

endmodule

// File: rtl/dcrs_rsp_gen.sv
module dcrs_rsp_gen
  import dcrs_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rsp_load_e         rsp_load,
  input  logic [WORD_W-1:0] hi_word,
  input  logic [WORD_W-1:0] lo_word,
  output logic [WORD_W-1:0] rsp_data,
  output logic              rsp_stat
);

  localparam logic [WORD_W-1:0] NREADY_CODE = '0;
  localparam logic [WORD_W-1:0] BERR_CODE   = WORD_W'(1);

  logic [WORD_W-1:0] data_q, data_d;
  logic              stat_q, stat_d;
  logic              load_en;

  assign load_en = (rsp_load != RSP_KEEP);

  always_comb begin
    data_d = NREADY_CODE;
    stat_d = 1'b1;
    case (rsp_load)
      RSP_HI:   begin data_d = hi_word;   stat_d = 1'b0; end
      RSP_LO:   begin data_d = lo_word;   stat_d = 1'b0; end
      RSP_BERR: begin data_d = BERR_CODE; stat_d = 1'b1; end
      default:  begin data_d = NREADY_CODE; stat_d = 1'b1; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= NREADY_CODE;
      stat_q <= 1'b1;
    end else if (load_en) begin
      data_q <= data_d;
      stat_q <= stat_d;
    end
  end

  assign rsp_data = data_q;
  assign rsp_stat = stat_q;

  AST_FLAG_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q |-> (data_q[WORD_W-1:1] == '0)); // R8

  AST_LO_AFTER_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_load == RSP_LO) |-> !stat_q); // R6

endmodule

// File: rtl/dcr_read_seq.sv
module dcr_read_seq
  import dcrs_pkg::*;
#(
  parameter int                WORD_W      = 16,
  parameter logic [WORD_W-1:0] CMD_CODE    = 16'h2980,
  parameter int                SYNC_STAGES = 2,
  localparam int               DATA_W      = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_xfer,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic              host_rstat,
  output logic              creg_req,
  output logic [DATA_W-1:0] creg_addr,
  input  logic              creg_ack,
  input  logic              creg_err,
  input  logic [DATA_W-1:0] creg_rdata
);

  logic              srst_n;
  logic              cap_hi, cap_lo, launch;
  logic              acc_done, acc_fail;
  logic [WORD_W-1:0] lo_word;
  rsp_load_e         rsp_load;

  dcrs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  dcrs_seq_fsm #(.WORD_W(WORD_W), .CMD_CODE(CMD_CODE)) u_fsm (
    .clk      (clk),
    .rst_n    (srst_n),
    .xfer     (host_xfer),
    .wdata    (host_wdata),
    .acc_done (acc_done),
    .acc_fail (acc_fail),
    .cap_hi   (cap_hi),
    .cap_lo   (cap_lo),
    .launch   (launch),
    .rsp_load (rsp_load)
  );

  dcrs_addr_cap #(.WORD_W(WORD_W)) u_addr (
    .clk    (clk),
    .rst_n  (srst_n),
    .cap_hi (cap_hi),
    .cap_lo (cap_lo),
    .wdata  (host_wdata),
    .addr   (creg_addr)
  );

  dcrs_bus_acc #(.WORD_W(WORD_W)) u_acc (
    .clk      (clk),
    .rst_n    (srst_n),
    .launch   (launch),
    .creg_ack (creg_ack),
    .creg_err (creg_err),
    .rdata_lo (creg_rdata[WORD_W-1:0]),
    .creg_req (creg_req),
    .acc_done (acc_done),
    .acc_fail (acc_fail),
    .lo_word  (lo_word)
  );

  dcrs_rsp_gen #(.WORD_W(WORD_W)) u_rsp (
    .clk      (clk),
    .rst_n    (srst_n),
    .rsp_load (rsp_load),
    .hi_word  (creg_rdata[DATA_W-1:WORD_W]),
    .lo_word  (lo_word),
    .rsp_data (host_rdata),
    .rsp_stat (host_rstat)
  );

  AST_NR_WHILE_PENDING: assert property (@(posedge clk) disable iff (!srst_n)
    (creg_req && host_xfer) |-> (host_rstat && host_rdata == '0)); // R5

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!srst_n)
    (creg_req && !creg_ack && !creg_err) |=> $stable(creg_addr)); // R4

  AST_REQ_FROM_HOST: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(creg_req) |-> $past(host_xfer)); // R2

endmodule

// File: tb/dcr_read_seq_tb_top.sv
module dcr_read_seq_tb_top;

  logic        clk;
  logic        rst_n;
  logic        host_xfer;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;
  logic        host_rstat;
  logic        creg_req;
  logic [31:0] creg_addr;
  logic        creg_ack;
  logic        creg_err;
  logic [31:0] creg_rdata;

  int checks;
  int failures;
  int lat;
  int cnt;
  bit finished;

  localparam logic [16:0] NR   = 17'h10000;
  localparam logic [16:0] BERR = 17'h10001;
  localparam logic [15:0] CMD  = 16'h2980;

  dcr_read_seq dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_xfer  (host_xfer),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .host_rstat (host_rstat),
    .creg_req   (creg_req),
    .creg_addr  (creg_addr),
    .creg_ack   (creg_ack),
    .creg_err   (creg_err),
    .creg_rdata (creg_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // register-port model: known selectors only, reserved bits must be zero
  function automatic logic [32:0] model_read(input logic [31:0] a);
    logic [11:0] s;
    logic        ok;
    s  = a[11:0];
    ok = (a[31:12] == '0) &&
         (s == 12'h002 || (s >= 12'h004 && s <= 12'h007) || s == 12'h801 ||
          (s >= 12'h804 && s <= 12'h806) || s == 12'h80E || s == 12'h80F ||
          s == 12'hC04 || s == 12'hC05 || s == 12'hC0F);
    return {ok, 4'hC, s, 4'h3, s};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      creg_ack   <= 1'b0;
      creg_err   <= 1'b0;
      creg_rdata <= '0;
      cnt        <= 0;
    end else if (creg_ack || creg_err) begin
      creg_ack <= 1'b0;
      creg_err <= 1'b0;
      cnt      <= 0;
    end else if (creg_req) begin
      if (cnt >= lat) begin
        logic [32:0] r;
        r = model_read(creg_addr);
        creg_ack   <= r[32];
        creg_err   <= ~r[32];
        creg_rdata <= r[31:0];
      end else begin
        cnt <= cnt + 1;
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one exchange; returns the packet delivered in it
  task automatic xchg(input logic [15:0] w, output logic [16:0] got);
    got        = {host_rstat, host_rdata};
    host_xfer  = 1'b1;
    host_wdata = w;
    @(posedge clk);
    #1 host_xfer = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_done();
    while (creg_req) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_val(input logic [11:0] s);
    return {4'hC, s, 4'h3, s};
  endfunction

  // command + two extension words, each must return not ready
  task automatic send_cmd(input logic [15:0] e1, input logic [15:0] e2);
    logic [16:0] g;
    xchg(CMD, g); chk("R3", "cmd word response", 32'(g), 32'(NR));
    xchg(e1, g);  chk("R3", "ext1 response", 32'(g), 32'(NR));
    xchg(e2, g);  chk("R3", "ext2 response", 32'(g), 32'(NR));
    chk("R4", "request raised", 32'(creg_req), 32'd1);
    chk("R4", "request address", creg_addr, {e1, e2});
  endtask

  task automatic t_reset();
    chk("R1", "reset response", 32'({host_rstat, host_rdata}), 32'(NR));
    chk("R1", "reset request", 32'(creg_req), 32'd0);
  endtask

  task automatic t_single_read(input logic [11:0] s);
    logic [16:0] g;
    lat = 0;
    send_cmd(16'h0000, {4'h0, s});
    wait_done();
    xchg(16'h0000, g); chk("R6", "upper half", 32'(g), 32'({1'b0, exp_val(s)[31:16]}));
    xchg(16'h0000, g); chk("R6", "lower half", 32'(g), 32'({1'b0, exp_val(s)[15:0]}));
    xchg(16'h0000, g); chk("R7", "idle after non-command", 32'(g), 32'(NR));
    chk("R9", "no request after read", 32'(creg_req), 32'd0);
  endtask

  task automatic t_pending();
    logic [16:0] g;
    lat = 8;
    send_cmd(16'h0000, 16'h0C0F);
    xchg(16'h1111, g); chk("R5", "exchange while pending", 32'(g), 32'(NR));
    xchg(16'h2980, g); chk("R5", "second exchange while pending", 32'(g), 32'(NR));
    for (int i = 0; i < 3; i++) begin
      chk("R4", "request held", 32'(creg_req), 32'd1);
      chk("R4", "address stable", creg_addr, 32'h00000C0F);
      @(negedge clk);
    end
    wait_done();
    xchg(16'h0000, g); chk("R5", "upper half after pending", 32'(g), 32'({1'b0, exp_val(12'hC0F)[31:16]}));
    xchg(16'h0000, g); chk("R5", "lower half after pending", 32'(g), 32'({1'b0, exp_val(12'hC0F)[15:0]}));
    lat = 0;
  endtask

  task automatic t_back_to_back();
    logic [16:0] g;
    lat = 1;
    send_cmd(16'h0000, 16'h0801);
    wait_done();
    xchg(16'h0000, g); chk("R6", "b2b upper", 32'(g), 32'({1'b0, exp_val(12'h801)[31:16]}));
    xchg(CMD, g);      chk("R7", "b2b lower with new command", 32'(g), 32'({1'b0, exp_val(12'h801)[15:0]}));
    xchg(16'h0000, g); chk("R7", "ext1 of overlapped command", 32'(g), 32'(NR));
    xchg(16'h0804, g); chk("R7", "ext2 of overlapped command", 32'(g), 32'(NR));
    chk("R7", "second request address", creg_addr, 32'h00000804);
    wait_done();
    xchg(16'h0000, g); chk("R7", "second upper", 32'(g), 32'({1'b0, exp_val(12'h804)[31:16]}));
    xchg(16'h0000, g); chk("R7", "second lower", 32'(g), 32'({1'b0, exp_val(12'h804)[15:0]}));
    lat = 0;
  endtask

  task automatic t_bad_cmd();
    logic [16:0] g;
    xchg(16'h2981, g); chk("R2", "wrong command response", 32'(g), 32'(NR));
    xchg(16'h0000, g); chk("R2", "word after wrong command", 32'(g), 32'(NR));
    xchg(16'h0805, g); chk("R2", "second word after wrong command", 32'(g), 32'(NR));
    @(negedge clk);
    chk("R2", "no request for wrong command", 32'(creg_req), 32'd0);
    xchg(16'h0000, g); chk("R2", "still not ready", 32'(g), 32'(NR));
  endtask

  task automatic t_error(input logic [15:0] e1, input logic [15:0] e2,
                         input logic [15:0] next_w);
    logic [16:0] g;
    send_cmd(e1, e2);
    wait_done();
    chk("R9", "request dropped after error", 32'(creg_req), 32'd0);
    xchg(next_w, g); chk("R8", "bus-error response", 32'(g), 32'(BERR));
    xchg(16'h0000, g); chk("R8", "not ready after bus error", 32'(g), 32'(NR));
  endtask

  task automatic t_error_then_cmd();
    logic [16:0] g;
    send_cmd(16'h0000, 16'h0123);
    wait_done();
    xchg(CMD, g);      chk("R8", "bus error with overlapped command", 32'(g), 32'(BERR));
    xchg(16'h0000, g); chk("R8", "ext1 after error", 32'(g), 32'(NR));
    xchg(16'h0006, g); chk("R8", "ext2 after error", 32'(g), 32'(NR));
    chk("R8", "request after error", creg_addr, 32'h00000006);
    wait_done();
    xchg(16'h0000, g); chk("R8", "upper after recovery", 32'(g), 32'({1'b0, exp_val(12'h006)[31:16]}));
    xchg(16'h0000, g); chk("R8", "lower after recovery", 32'(g), 32'({1'b0, exp_val(12'h006)[15:0]}));
  endtask

  initial begin
    checks = 0; failures = 0; lat = 0; finished = 0;
    rst_n = 1'b0; host_xfer = 1'b0; host_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_single_read(12'h002);
    t_single_read(12'h80F);
    t_pending();
    t_back_to_back();
    t_bad_cmd();
    t_single_read(12'hC05);
    t_error(16'h0000, 16'h0123, 16'h0000);  // unmapped selector
    t_error(16'h0001, 16'h0002, 16'h0000);  // reserved upper word
    t_error(16'h0000, 16'h1002, 16'h0000);  // reserved nibble
    t_error_then_cmd();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule